// File: doc/BRIEF.md
# Security-Aware Exception Priority Resolver

This block sits in a small interrupt controller that has a two-bank security extension. Each cycle it looks at the pending exceptions and works out an effective priority for each one. Reset, NMI and the two copies of hard fault have fixed negative priorities. Programmable exceptions get a group priority: their raw priority with the subpriority bits cleared, where the split point comes from the security bank the exception targets. The block picks the most urgent pending exception and registers its vector number, its bank flag and its group priority.

The block also judges a synchronous fault that the core reports, together with the fault's raw priority and bank. When that fault cannot pre-empt the current execution priority, it must be escalated to hard fault. When the chosen hard-fault copy cannot pre-empt either, the core must enter lockup. Which hard-fault copy is chosen, and how urgent it is, depends on a control bit. That bit moves the secure hard fault above NMI.

Top module: `excprio_top`

## Requirements
- R1: After reset, and until an exception is pending, the registered outputs are idle: `winValid`=0, `winVec`=0, `winSecure`=0, `winPrio`=255.
- R2: The fixed exceptions have these vector numbers and priorities: reset is vector 1 at -4, NMI is vector 2 at -2, and the non-secure hard fault is vector 3 at -1 with `winSecure`=0.
- R3: The secure hard fault is vector 3 with `winSecure`=1. Its priority is -3 when `hfAboveNmi`=1 and -1 when `hfAboveNmi`=0. A change of `hfAboveNmi` shows in the registered priority one clock later.
- R4: Programmable exception k is vector 4+k and reports `winSecure`=`irqSecure[k]`. Its raw priority is `irqPrio[8k+7:8k]`. Its group priority is that raw value with bits [s:0] cleared, where s is `splitSec` if `irqSecure[k]`=1 and `splitNs` otherwise.
- R5: No group mask is ever applied to the fixed negative priorities. NMI always beats a non-secure hard fault, whatever the split fields hold.
- R6: The winner has the numerically lowest priority. On a tie the lower vector number wins. On a tie within vector 3, the secure copy wins.
- R7: The winner is registered. Outputs reflect the inputs sampled at the previous rising clock edge, and they return to the idle values of R1 when nothing is pending.
- R8: With `faultValid`=1, the fault needs escalation when the group priority of `faultPrio` is greater than or equal to `execPrio`. The group priority is formed as in R4, using `splitSec` if `faultSecure`=1 and `splitNs` otherwise. In that case `escalate`=1 unless R9 gives lockup.
- R9: The target hard fault is the secure copy when `faultSecure`=1 or `hfAboveNmi`=0, and the non-secure copy otherwise. Its priority follows R2 and R3. `lockup`=1 when escalation is needed and `execPrio` is less than or equal to that priority.
- R10: `escalate` and `lockup` are never both 1. Both are 0 when `faultValid`=0. Both are combinational in the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hfAboveNmi | input | 1 | 1 moves the secure hard fault to -3, above NMI |
| splitSec | input | 3 | Group split field for the secure bank |
| splitNs | input | 3 | Group split field for the non-secure bank |
| pendReset | input | 1 | Reset exception pending |
| pendNmi | input | 1 | NMI pending |
| pendHfSec | input | 1 | Secure hard fault pending |
| pendHfNs | input | 1 | Non-secure hard fault pending |
| pendIrq | input | NUM_PROG | Programmable exceptions pending |
| irqPrio | input | NUM_PROG*PRIO_W | Raw priorities, 8 bits each, exception k at [8k+7:8k] |
| irqSecure | input | NUM_PROG | Bank targeted by each programmable exception |
| execPrio | input | 9 | Current execution priority, signed |
| faultValid | input | 1 | Synchronous fault being judged |
| faultPrio | input | PRIO_W | Raw priority of the faulting exception |
| faultSecure | input | 1 | Bank of the faulting exception |
| winValid | output | 1 | Registered: a winner exists |
| winVec | output | VEC_W | Registered winning vector number |
| winSecure | output | 1 | Registered: winner is the secure copy / targets secure |
| winPrio | output | 9 | Registered signed group priority of the winner |
| escalate | output | 1 | Fault must become a hard fault |
| lockup | output | 1 | Fault must cause lockup |

## Verification
The bench sweeps every combination of the four fixed exceptions under both settings of the control bit. It also sweeps every pair of split fields across many pending and bank patterns. A design that masked negative priorities would let hard fault tie NMI. A design that used the wrong bank's split field, or broke ties towards the higher vector or the non-secure copy, would name the wrong winner. The fault sweep crosses execution priorities from -4 to 255 with fault priorities, banks and splits. It catches comparisons against the raw priority instead of the group priority, and an off-by-one at equality. It also catches a lockup test that assumes hard fault is always -1, which goes wrong when a secure fault meets an execution priority of -2 with the control bit set.

// File: rtl/excprio_pkg.sv
package excprio_pkg;

  typedef logic signed [8:0] prio_t;

  localparam prio_t PRIO_IDLE    = 9'sd255;
  localparam prio_t PRIO_RESET   = -9'sd4;
  localparam prio_t PRIO_HF_HIGH = -9'sd3;
  localparam prio_t PRIO_NMI     = -9'sd2;
  localparam prio_t PRIO_HF_LOW  = -9'sd1;

  // candidate slots, in tie-break order
  localparam int SLOT_RESET  = 0;
  localparam int SLOT_NMI    = 1;
  localparam int SLOT_HF_SEC = 2;
  localparam int SLOT_HF_NS  = 3;
  localparam int SLOT_PROG   = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic       load;
    logic       idle;
    logic [7:0] sel;
  } strobe_t;

  // datapath -> control compare flags
  typedef struct packed {
    logic faultBlocked;
    logic hfBlocked;
  } cmp_t;

endpackage

// File: rtl/excprio_datapath.sv
module excprio_datapath
  import excprio_pkg::*;
#(
  parameter int NUM_PROG = 4,
  parameter int PRIO_W   = 8,
  parameter int SPLIT_W  = 3,
  parameter int NCAND    = NUM_PROG + 4,
  parameter int IDX_W    = $clog2(NUM_PROG + 4)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hfAboveNmi,
  input  logic [SPLIT_W-1:0]           splitSec,
  input  logic [SPLIT_W-1:0]           splitNs,
  input  logic                         pendReset,
  input  logic                         pendNmi,
  input  logic                         pendHfSec,
  input  logic                         pendHfNs,
  input  logic [NUM_PROG-1:0]          pendIrq,
  input  logic [NUM_PROG*PRIO_W-1:0]   irqPrio,
  input  logic [NUM_PROG-1:0]          irqSecure,
  input  prio_t                        execPrio,
  input  logic [PRIO_W-1:0]            faultPrio,
  input  logic                         faultSecure,
  input  strobe_t                      strobe,
  output logic [NCAND-1:0]             candValid,
  output prio_t [NCAND-1:0]            candPrio,
  output cmp_t                         cmp,
  output logic                         winValid,
  output logic [IDX_W-1:0]             winVec,
  output logic                         winSecure,
  output prio_t                        winPrio
);

  localparam int ZPAD = 9 - PRIO_W;

  // group priority: clear bits [split:0], never used on fixed priorities
  function automatic prio_t groupOf(input logic [PRIO_W-1:0] raw,
                                    input logic [SPLIT_W-1:0] split);
    logic [PRIO_W-1:0] g;
    for (int i = 0; i < PRIO_W; i++) begin
      g[i] = (i > int'(split)) ? raw[i] : 1'b0;
    end
    return prio_t'({{ZPAD{1'b0}}, g});
  endfunction

  // fixed candidates
  always_comb begin
    candValid[SLOT_RESET]  = pendReset;
    candValid[SLOT_NMI]    = pendNmi;
    candValid[SLOT_HF_SEC] = pendHfSec;
    candValid[SLOT_HF_NS]  = pendHfNs;
    candPrio[SLOT_RESET]   = PRIO_RESET;
    candPrio[SLOT_NMI]     = PRIO_NMI;
    candPrio[SLOT_HF_SEC]  = hfAboveNmi ? PRIO_HF_HIGH : PRIO_HF_LOW;
    candPrio[SLOT_HF_NS]   = PRIO_HF_LOW;
  end

  // programmable candidates
  for (genvar k = 0; k < NUM_PROG; k++) begin : g_prog
    logic [SPLIT_W-1:0] bankSplit;
    assign bankSplit = irqSecure[k] ? splitSec : splitNs;
    assign candValid[SLOT_PROG+k] = pendIrq[k];
    assign candPrio[SLOT_PROG+k]  = groupOf(irqPrio[k*PRIO_W +: PRIO_W], bankSplit);
  end

  // fault judgement: group priority from the fault's own bank
  prio_t faultGroup;
  prio_t hfTargetPrio;
  logic  hfTargetSec;

  always_comb begin
    faultGroup       = groupOf(faultPrio, faultSecure ? splitSec : splitNs);
    hfTargetSec      = faultSecure || !hfAboveNmi;
    hfTargetPrio     = (hfTargetSec && hfAboveNmi) ? PRIO_HF_HIGH : PRIO_HF_LOW;
    cmp.faultBlocked = (faultGroup >= execPrio);
    cmp.hfBlocked    = (execPrio <= hfTargetPrio);
  end

  // decode selected slot to vector number and bank
  logic [IDX_W-1:0] selIdx;
  logic [IDX_W-1:0] selVec;
  logic             selSec;

  assign selIdx = strobe.sel[IDX_W-1:0];

  always_comb begin
    selSec = 1'b0;
    if (selIdx == IDX_W'(SLOT_RESET)) begin
      selVec = IDX_W'(1);
    end else if (selIdx == IDX_W'(SLOT_NMI)) begin
      selVec = IDX_W'(2);
    end else if (selIdx == IDX_W'(SLOT_HF_SEC)) begin
      selVec = IDX_W'(3);
      selSec = 1'b1;
    end else if (selIdx == IDX_W'(SLOT_HF_NS)) begin
      selVec = IDX_W'(3);
    end else begin
      selVec = selIdx;
      for (int k = 0; k < NUM_PROG; k++) begin
        if (selIdx == IDX_W'(SLOT_PROG + k)) selSec = irqSecure[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winValid  <= 1'b0;
      winVec    <= '0;
      winSecure <= 1'b0;
      winPrio   <= PRIO_IDLE;
    end else if (strobe.load) begin
      winValid  <= 1'b1;
      winVec    <= selVec;
      winSecure <= selSec;
      winPrio   <= candPrio[selIdx];
    end else if (strobe.idle) begin
      winValid  <= 1'b0;
      winVec    <= '0;
      winSecure <= 1'b0;
      winPrio   <= PRIO_IDLE;
    end
  end

  // fixed vectors always carry negative, unmasked priorities
  assert_fixed_negative_R5: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winVec < IDX_W'(SLOT_PROG)) |-> (winPrio < 9'sd0));

  // programmable winners carry a group priority with bit 0 cleared
  assert_group_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winVec >= IDX_W'(SLOT_PROG)) |-> (winPrio[0] == 1'b0 && winPrio >= 9'sd0));

endmodule

// File: rtl/excprio_control.sv
module excprio_control
  import excprio_pkg::*;
#(
  parameter int NCAND = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NCAND-1:0]    candValid,
  input  prio_t [NCAND-1:0]   candPrio,
  input  cmp_t                cmp,
  input  logic                faultValid,
  output strobe_t             strobe,
  output logic                escalate,
  output logic                lockup
);

  // scan in slot order; strict less-than keeps the earlier slot on a tie
  logic  found;
  int    bestIdx;
  prio_t bestPrio;

  always_comb begin
    found    = 1'b0;
    bestIdx  = 0;
    bestPrio = PRIO_IDLE;
    for (int i = 0; i < NCAND; i++) begin
      if (candValid[i] && (!found || candPrio[i] < bestPrio)) begin
        found    = 1'b1;
        bestIdx  = i;
        bestPrio = candPrio[i];
      end
    end
    strobe.load = found;
    strobe.idle = !found;
    strobe.sel  = 8'(bestIdx);
  end

  logic needHf;
  assign needHf   = faultValid && cmp.faultBlocked;
  assign lockup   = needHf && cmp.hfBlocked;
  assign escalate = needHf && !cmp.hfBlocked;

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(escalate && lockup));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> (!escalate && !lockup));

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({strobe.load, strobe.idle}));

endmodule

// File: rtl/excprio_top.sv
module excprio_top
  import excprio_pkg::*;
#(
  parameter int NUM_PROG = 4,
  parameter int PRIO_W   = 8,
  parameter int SPLIT_W  = 3,
  localparam int VEC_W   = $clog2(NUM_PROG + 4)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hfAboveNmi,
  input  logic [SPLIT_W-1:0]           splitSec,
  input  logic [SPLIT_W-1:0]           splitNs,
  input  logic                         pendReset,
  input  logic                         pendNmi,
  input  logic                         pendHfSec,
  input  logic                         pendHfNs,
  input  logic [NUM_PROG-1:0]          pendIrq,
  input  logic [NUM_PROG*PRIO_W-1:0]   irqPrio,
  input  logic [NUM_PROG-1:0]          irqSecure,
  input  logic signed [8:0]            execPrio,
  input  logic                         faultValid,
  input  logic [PRIO_W-1:0]            faultPrio,
  input  logic                         faultSecure,
  output logic                         winValid,
  output logic [VEC_W-1:0]             winVec,
  output logic                         winSecure,
  output logic signed [8:0]            winPrio,
  output logic                         escalate,
  output logic                         lockup
);

  localparam int NCAND = NUM_PROG + 4;

  logic [NCAND-1:0]  candValid;
  prio_t [NCAND-1:0] candPrio;
  cmp_t              cmp;
  strobe_t           strobe;

  excprio_datapath #(
    .NUM_PROG(NUM_PROG), .PRIO_W(PRIO_W), .SPLIT_W(SPLIT_W),
    .NCAND(NCAND), .IDX_W(VEC_W)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .hfAboveNmi(hfAboveNmi),
    .splitSec(splitSec), .splitNs(splitNs),
    .pendReset(pendReset), .pendNmi(pendNmi),
    .pendHfSec(pendHfSec), .pendHfNs(pendHfNs),
    .pendIrq(pendIrq), .irqPrio(irqPrio), .irqSecure(irqSecure),
    .execPrio(execPrio), .faultPrio(faultPrio), .faultSecure(faultSecure),
    .strobe(strobe), .candValid(candValid), .candPrio(candPrio), .cmp(cmp),
    .winValid(winValid), .winVec(winVec), .winSecure(winSecure), .winPrio(winPrio)
  );

  excprio_control #(.NCAND(NCAND)) control_i (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candPrio(candPrio),
    .cmp(cmp), .faultValid(faultValid), .strobe(strobe),
    .escalate(escalate), .lockup(lockup)
  );

  assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    pendReset |=> (winVec == VEC_W'(1) && winPrio == -9'sd4 && !winSecure));

  assert_sec_hf_above_nmi_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pendHfSec && hfAboveNmi && !pendReset) |=> (winVec == VEC_W'(3) && winSecure && winPrio == -9'sd3));

  assert_nmi_over_hf_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendNmi && !pendReset && !(pendHfSec && hfAboveNmi)) |=> (winVec == VEC_W'(2) && winPrio == -9'sd2));

  assert_lockup_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    lockup |-> (execPrio <= -9'sd1));

endmodule

// File: tb/excprio_top_tb_top.sv
module excprio_top_tb_top;

  localparam int NP = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              hfAboveNmi;
  logic [2:0]        splitSec, splitNs;
  logic              pendReset, pendNmi, pendHfSec, pendHfNs;
  logic [NP-1:0]     pendIrq;
  logic [NP*8-1:0]   irqPrio;
  logic [NP-1:0]     irqSecure;
  logic signed [8:0] execPrio;
  logic              faultValid;
  logic [7:0]        faultPrio;
  logic              faultSecure;
  logic              winValid;
  logic [2:0]        winVec;
  logic              winSecure;
  logic signed [8:0] winPrio;
  logic              escalate, lockup;

  int compared   = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  excprio_top #(.NUM_PROG(NP), .PRIO_W(8), .SPLIT_W(3)) dut_i (
    .clk(clk), .rstN(rstN), .hfAboveNmi(hfAboveNmi),
    .splitSec(splitSec), .splitNs(splitNs),
    .pendReset(pendReset), .pendNmi(pendNmi), .pendHfSec(pendHfSec), .pendHfNs(pendHfNs),
    .pendIrq(pendIrq), .irqPrio(irqPrio), .irqSecure(irqSecure),
    .execPrio(execPrio), .faultValid(faultValid), .faultPrio(faultPrio),
    .faultSecure(faultSecure), .winValid(winValid), .winVec(winVec),
    .winSecure(winSecure), .winPrio(winPrio), .escalate(escalate), .lockup(lockup)
  );

  function automatic logic signed [8:0] grp(input logic [7:0] raw, input logic [2:0] s);
    int sh = int'(s) + 1;
    return 9'((int'(raw) >> sh) << sh);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // expected winner from the requirement rules, then compare after one edge
  task automatic checkWin(input string tag);
    logic              found = 1'b0;
    logic [2:0]        eVec = 3'd0;
    logic              eSec = 1'b0;
    logic signed [8:0] eP = 9'sd255;
    logic              cv [8];
    logic signed [8:0] cp [8];
    cv[0] = pendReset; cp[0] = -9'sd4;
    cv[1] = pendNmi;   cp[1] = -9'sd2;
    cv[2] = pendHfSec; cp[2] = hfAboveNmi ? -9'sd3 : -9'sd1;
    cv[3] = pendHfNs;  cp[3] = -9'sd1;
    for (int k = 0; k < NP; k++) begin
      cv[4+k] = pendIrq[k];
      cp[4+k] = grp(irqPrio[k*8 +: 8], irqSecure[k] ? splitSec : splitNs);
    end
    for (int i = 0; i < 8; i++) begin
      if (cv[i] && (!found || cp[i] < eP)) begin
        found = 1'b1;
        eP    = cp[i];
        eVec  = (i == 0) ? 3'd1 : (i == 1) ? 3'd2 : (i < 4) ? 3'd3 : 3'(i);
        eSec  = (i == 2) ? 1'b1 : (i >= 4) ? irqSecure[i-4] : 1'b0;
      end
    end
    tick();
    compared++;
    if (winValid !== found || winVec !== eVec || winSecure !== eSec || winPrio !== eP) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b vec=%0d sec=%0b prio=%0d, expected valid=%0b vec=%0d sec=%0b prio=%0d",
               tag, winValid, winVec, winSecure, winPrio, found, eVec, eSec, eP);
    end
  endtask

  task automatic checkFault();
    logic signed [8:0] g, hfp;
    logic need, eLock, eEsc;
    string tag;
    g     = grp(faultPrio, faultSecure ? splitSec : splitNs);
    hfp   = (faultSecure && hfAboveNmi) ? -9'sd3 : -9'sd1;
    need  = faultValid && (g >= execPrio);
    eLock = need && (execPrio <= hfp);
    eEsc  = need && !eLock;
    tag   = !faultValid ? "R10" : eLock ? "R9" : "R8";
    #1;
    compared++;
    if (escalate !== eEsc || lockup !== eLock) begin
      mismatched++;
      $display("FAIL %s: exec=%0d fprio=%0d sec=%0b ctl=%0b got esc=%0b lock=%0b expected esc=%0b lock=%0b",
               tag, execPrio, faultPrio, faultSecure, hfAboveNmi, escalate, lockup, eEsc, eLock);
    end
  endtask

  task automatic clearPend();
    {pendReset, pendNmi, pendHfSec, pendHfNs} = 4'b0;
    pendIrq = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int execList [11] = '{-4, -3, -2, -1, 0, 1, 32, 64, 128, 200, 255};
    rstN = 1'b0; hfAboveNmi = 1'b0; splitSec = 3'd0; splitNs = 3'd0;
    clearPend(); irqPrio = '0; irqSecure = '0; execPrio = 9'sd0;
    faultValid = 1'b0; faultPrio = 8'd0; faultSecure = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: idle after reset with nothing pending
    checkWin("R1");

    // R2 R3 R5 R6: every combination of fixed exceptions, both control settings
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 16; m++) begin
        hfAboveNmi = c[0];
        {pendHfNs, pendHfSec, pendNmi, pendReset} = m[3:0];
        splitSec = 3'(m); splitNs = 3'(7 - m);
        if (m == 0)                      checkWin("R7");
        else if (m[0])                   checkWin("R2");
        else if (m[2] && m[3] && !m[1])  checkWin("R6");
        else if (m[2])                   checkWin("R3");
        else                             checkWin("R5");
      end
    end

    // R3: control bit flip re-ranks secure hard fault against NMI
    clearPend(); pendNmi = 1'b1; pendHfSec = 1'b1; hfAboveNmi = 1'b0;
    checkWin("R3");
    hfAboveNmi = 1'b1;
    checkWin("R3");
    hfAboveNmi = 1'b0;
    checkWin("R3");

    // R5: largest split must not merge NMI and hard fault
    clearPend(); pendNmi = 1'b1; pendHfNs = 1'b1; splitSec = 3'd7; splitNs = 3'd7;
    checkWin("R5");

    // R7: back to idle when pending drops
    clearPend();
    checkWin("R7");

    // R4 R6: split pairs x pending patterns x bank patterns
    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n < 8; n++) begin
        for (int p = 1; p < 16; p++) begin
          clearPend();
          splitSec = 3'(s); splitNs = 3'(n);
          pendIrq = 4'(p);
          for (int k = 0; k < NP; k++) begin
            irqPrio[k*8 +: 8] = 8'((37 * k + 53 * s + 11 * n + 29 * p) & 255);
            irqSecure[k] = 1'((k + s + p) & 1);
          end
          if ($countones(pendIrq) == 1) checkWin("R4");
          else                           checkWin("R6");
        end
      end
    end

    // R6: group tie resolved by lower vector although raw priority is larger
    clearPend(); splitSec = 3'd4; splitNs = 3'd4; irqSecure = 4'b0000;
    irqPrio = {8'h00, 8'h00, 8'h10, 8'h1F};
    pendIrq = 4'b0011;
    checkWin("R6");

    // fault judgement sweep
    clearPend();
    for (int c = 0; c < 2; c++) begin
      for (int fs = 0; fs < 2; fs++) begin
        for (int s = 0; s < 8; s++) begin
          for (int e = 0; e < 11; e++) begin
            for (int fp = 0; fp < 256; fp += 15) begin
              hfAboveNmi = c[0]; faultSecure = fs[0];
              splitSec = 3'(s); splitNs = 3'(7 - s);
              execPrio = 9'(execList[e]);
              faultPrio = 8'(fp);
              faultValid = 1'b1;
              checkFault();
              if (fp == 0) begin
                faultValid = 1'b0;
                checkFault();
              end
            end
          end
        end
      end
    end

    // R9: secure fault reaches the raised hard fault, non-secure does not
    hfAboveNmi = 1'b1; faultValid = 1'b1; faultPrio = 8'd40; execPrio = -9'sd2;
    splitSec = 3'd0; splitNs = 3'd0;
    faultSecure = 1'b1; checkFault();
    faultSecure = 1'b0; checkFault();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule